// File: doc/BRIEF.md
# Configurable Timer Counter Channel

This block is one 16-bit up-counting timer channel. A set of control fields chooses where its count pulses come from, which edges of an external clock pin are counted, and what resets the counter to zero. The count source is either the system clock, a divided version of it (by 2, 4 or 8), or one of four external clock pins. Divided clocks are produced as one-cycle count-enable pulses from a free-running prescaler, so the whole channel runs on the single system clock.

Two general registers, A and B, each work either as an output-compare register or as an input-capture register. In compare mode a match flag shows when the counter equals the compare value. In capture mode an edge on that register's capture pin latches the counter. The counter can be cleared by an event on register A or B, or by a clear shared with other synchronized channels. A clear pulse output lets those other channels follow this one.

A phase-counting mode input only blocks edge counting of the external pins; the phase decoder itself is outside this block.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter, both captured values and the clear pulse output are 0.
- R2: With source select 000 the counter adds one on every system clock cycle and wraps from 0xFFFF to 0x0000.
- R3: Source selects 001, 010 and 011 give exactly one increment per 2, 4 and 8 system cycles.
- R4: Source selects 100, 101, 110 and 111 count edges of external pins 0, 1, 2 and 3. Edges on the other pins have no effect on the count.
- R5: Edge select 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. A pin change made between two clock edges shows in the count after the third rising clock edge.
- R6: With phase mode high, external pin edges never increment the counter, whatever the edge select. Internal sources keep counting.
- R7: A match flag is high exactly when its register is in compare mode (capture-mode bit 0) and the counter equals that register's compare value.
- R8: Clear select 01 or 10 with the chosen register in compare mode: on a count pulse while the counter equals the compare value, the counter goes to 0. The clear pulse output is high in that cycle.
- R9: In capture mode (capture-mode bit 1), a capture-pin edge of the kind chosen by the capture edge select loads the counter into that register's captured value. The encoding is the same as the edge select. The value loaded is the count two cycles after the pin change. In compare mode the captured value holds.
- R10: Clear select 01 or 10 with the chosen register in capture mode clears the counter on the capture event. The captured value is the count from before the clear, and the clear pulse output is high in that cycle.
- R11: Clear select 11 clears the counter in any cycle where both the synchro-enable input and the shared clear input are high. The clear pulse output stays low, and the shared clear input has no effect while synchro-enable is low.
- R12: Clear select 00 never clears the counter and never raises the clear pulse output, even on a compare match.
- R13: A clear beats an increment in the same cycle: the counter reads 0 rather than the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClkPin | input | 4 | External clock pins 0 to 3 |
| srcSel | input | 3 | Count source select |
| edgeSel | input | 2 | External clock edge select |
| clrSel | input | 2 | Counter clear source select |
| phaseMode | input | 1 | Phase-counting mode; blocks external edge counting |
| syncEn | input | 1 | Channel takes part in the synchronized clear |
| syncClrIn | input | 1 | Clear request from the other synchronized channels |
| capModeA | input | 1 | Register A role: 0 compare, 1 capture |
| capModeB | input | 1 | Register B role: 0 compare, 1 capture |
| capEdgeSel | input | 2 | Capture pin edge select |
| capPinA | input | 1 | Capture pin for register A |
| capPinB | input | 1 | Capture pin for register B |
| cmpValA | input | 16 | Compare value of register A |
| cmpValB | input | 16 | Compare value of register B |
| count | output | 16 | Counter value |
| matchA | output | 1 | Compare match flag of register A |
| matchB | output | 1 | Compare match flag of register B |
| capValA | output | 16 | Captured value of register A |
| capValB | output | 16 | Captured value of register B |
| clrOut | output | 1 | Pulse marking a clear this channel caused itself |

## Verification
The assertions assume that the shared clear input comes from other channels and never combinationally from this channel's own clear pulse. They also assume that control fields, compare values and modes settle before the rising clock edge that uses them. The bench changes every input only just after a falling edge. It holds the shared clear input as an independent random or directed value, never a function of the clear output. It keeps the pins high or low long enough for the three-cycle synchronizer path to see every edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic inc;
    logic clr;
    logic capA;
    logic capB;
  } tmrStrobe_t;

  // Edge choice shared by external clocks and capture pins:
  // 00 rising, 01 falling, 1x both.
  function automatic logic edgePick(input logic [1:0] sel,
                                    input logic rise,
                                    input logic fall);
    if (sel[1])      return rise | fall;
    else if (sel[0]) return fall;
    else             return rise;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] syncReg;
  logic              prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncReg <= {syncReg[STAGES-2:0], pin};
      prevLvl <= syncReg[STAGES-1];
    end
  end

  assign rise = syncReg[STAGES-1] & ~prevLvl;
  assign fall = ~syncReg[STAGES-1] & prevLvl;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int PRE_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extRise,
  input  logic [NUM_EXT-1:0] extFall,
  input  logic               capRiseA,
  input  logic               capFallA,
  input  logic               capRiseB,
  input  logic               capFallB,
  input  logic [2:0]         srcSel,
  input  logic [1:0]         edgeSel,
  input  logic [1:0]         clrSel,
  input  logic               phaseMode,
  input  logic               syncEn,
  input  logic               syncClrIn,
  input  logic               capModeA,
  input  logic               capModeB,
  input  logic [1:0]         capEdgeSel,
  input  logic               eqA,
  input  logic               eqB,
  output tmrStrobe_t         strobe,
  output logic               matchA,
  output logic               matchB,
  output logic               clrOut
);
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   divMask;
  logic [NUM_EXT-1:0] extTickVec;
  logic               divTick, extTick, tick;
  logic               capEvA, capEvB, evA, evB, localClr, syncClr;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    divMask = PRE_W'((32'd1 << srcSel[1:0]) - 32'd1);
    divTick = ((preCnt & divMask) == divMask);
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    assign extTickVec[i] = ~phaseMode & edgePick(edgeSel, extRise[i], extFall[i]);
  end

  assign extTick = extTickVec[srcSel[1:0]];
  assign tick    = srcSel[2] ? extTick : divTick;

  assign capEvA = capModeA & edgePick(capEdgeSel, capRiseA, capFallA);
  assign capEvB = capModeB & edgePick(capEdgeSel, capRiseB, capFallB);

  assign matchA = ~capModeA & eqA;
  assign matchB = ~capModeB & eqB;

  assign evA = capModeA ? capEvA : (tick & matchA);
  assign evB = capModeB ? capEvB : (tick & matchB);

  assign localClr = ((clrSel == 2'b01) & evA) | ((clrSel == 2'b10) & evB);
  assign syncClr  = (clrSel == 2'b11) & syncEn & syncClrIn;

  assign clrOut      = localClr;
  assign strobe.inc  = tick;
  assign strobe.clr  = localClr | syncClr;
  assign strobe.capA = capEvA;
  assign strobe.capB = capEvB;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpValA,
  input  logic [CNT_W-1:0] cmpValB,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capValA,
  output logic [CNT_W-1:0] capValB,
  output logic             eqA,
  output logic             eqB
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      capValA <= '0;
      capValB <= '0;
    end else begin
      if (strobe.clr)      count <= '0;
      else if (strobe.inc) count <= count + 1'b1;
      if (strobe.capA) capValA <= count;
      if (strobe.capB) capValB <= count;
    end
  end

  assign eqA = (count == cmpValA);
  assign eqB = (count == cmpValB);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_EXT     = 4,
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extClkPin,
  input  logic [2:0]         srcSel,
  input  logic [1:0]         edgeSel,
  input  logic [1:0]         clrSel,
  input  logic               phaseMode,
  input  logic               syncEn,
  input  logic               syncClrIn,
  input  logic               capModeA,
  input  logic               capModeB,
  input  logic [1:0]         capEdgeSel,
  input  logic               capPinA,
  input  logic               capPinB,
  input  logic [CNT_W-1:0]   cmpValA,
  input  logic [CNT_W-1:0]   cmpValB,
  output logic [CNT_W-1:0]   count,
  output logic               matchA,
  output logic               matchB,
  output logic [CNT_W-1:0]   capValA,
  output logic [CNT_W-1:0]   capValB,
  output logic               clrOut
);
  logic [NUM_EXT-1:0] extRise, extFall;
  logic               capRiseA, capFallA, capRiseB, capFallB;
  logic               eqA, eqB;
  tmrStrobe_t         strobe;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_extSync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .pin(extClkPin[i]),
      .rise(extRise[i]), .fall(extFall[i]));
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_capSyncA (
    .clk(clk), .rstN(rstN), .pin(capPinA), .rise(capRiseA), .fall(capFallA));
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_capSyncB (
    .clk(clk), .rstN(rstN), .pin(capPinB), .rise(capRiseB), .fall(capFallB));

  tmr_ctrl #(.NUM_EXT(NUM_EXT), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .extRise(extRise), .extFall(extFall),
    .capRiseA(capRiseA), .capFallA(capFallA),
    .capRiseB(capRiseB), .capFallB(capFallB),
    .srcSel(srcSel), .edgeSel(edgeSel), .clrSel(clrSel),
    .phaseMode(phaseMode), .syncEn(syncEn), .syncClrIn(syncClrIn),
    .capModeA(capModeA), .capModeB(capModeB), .capEdgeSel(capEdgeSel),
    .eqA(eqA), .eqB(eqB), .strobe(strobe),
    .matchA(matchA), .matchB(matchB), .clrOut(clrOut));

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmpValA(cmpValA), .cmpValB(cmpValB),
    .count(count), .capValA(capValA), .capValB(capValB),
    .eqA(eqA), .eqB(eqB));
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       srcSel,
  input logic [1:0]       clrSel,
  input logic             phaseMode,
  input logic             syncEn,
  input logic             syncClrIn,
  input logic             capModeA,
  input logic [CNT_W-1:0] count,
  input logic             matchA,
  input logic [CNT_W-1:0] capValA,
  input logic             clrOut
);
  logic syncHit;
  assign syncHit = (clrSel == 2'b11) && syncEn && syncClrIn;

  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 3'b000 && !clrOut && !syncHit) |=> count == $past(count) + 1'b1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 3'b000 && clrSel == 2'b00 && count == '1) |=> count == '0);

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel[2] && phaseMode && !clrOut && !syncHit) |=> $stable(count));

  p_cmp_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 3'b000 && clrSel == 2'b01 && matchA) |=> count == '0);

  p_clr_wins_r13: assert property (@(posedge clk) disable iff (!rstN)
    clrOut |=> count == '0);

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !capModeA |=> $stable(capValA));

  p_sync_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    syncHit |=> count == '0);

  p_no_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (clrSel == 2'b00) |-> !clrOut);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .clrSel(clrSel),
  .phaseMode(phaseMode), .syncEn(syncEn), .syncClrIn(syncClrIn),
  .capModeA(capModeA), .count(count), .matchA(matchA),
  .capValA(capValA), .clrOut(clrOut));

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  extClkPin;
  logic [2:0]  srcSel;
  logic [1:0]  edgeSel, clrSel, capEdgeSel;
  logic        phaseMode, syncEn, syncClrIn, capModeA, capModeB, capPinA, capPinB;
  logic [15:0] cmpValA, cmpValB, count, capValA, capValB;
  logic        matchA, matchB, clrOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rstN(rstN), .extClkPin(extClkPin), .srcSel(srcSel),
    .edgeSel(edgeSel), .clrSel(clrSel), .phaseMode(phaseMode),
    .syncEn(syncEn), .syncClrIn(syncClrIn), .capModeA(capModeA),
    .capModeB(capModeB), .capEdgeSel(capEdgeSel), .capPinA(capPinA),
    .capPinB(capPinB), .cmpValA(cmpValA), .cmpValB(cmpValB),
    .count(count), .matchA(matchA), .matchB(matchB),
    .capValA(capValA), .capValB(capValB), .clrOut(clrOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zeroCount();
    clrSel = 2'b11; syncEn = 1'b1; syncClrIn = 1'b1;
    cyc(1);
    clrSel = 2'b00; syncEn = 1'b0; syncClrIn = 1'b0;
  endtask

  task automatic pulseExt(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      extClkPin[idx] = 1'b1; cyc(4);
      extClkPin[idx] = 1'b0; cyc(4);
    end
  endtask

  function automatic logic [15:0] modelNext(input logic [15:0] c);
    if ((clrSel == 2'b01 && c == cmpValA) || (clrSel == 2'b10 && c == cmpValB) ||
        (clrSel == 2'b11 && syncEn && syncClrIn))
      return 16'd0;
    return c + 16'd1;
  endfunction

  function automatic bit modelClrOut(input logic [15:0] c);
    return (clrSel == 2'b01 && c == cmpValA) || (clrSel == 2'b10 && c == cmpValB);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0, expNext;
    void'($urandom(32'd2024));
    rstN = 1'b0; extClkPin = '0; srcSel = '0; edgeSel = '0; clrSel = '0;
    phaseMode = 0; syncEn = 0; syncClrIn = 0; capModeA = 0; capModeB = 0;
    capEdgeSel = '0; capPinA = 0; capPinB = 0; cmpValA = 16'hFFF0; cmpValB = 16'hFFF0;
    cyc(3);
    check(count == 0, "R1 count", count, 0);
    check(capValA == 0 && capValB == 0, "R1 capture", capValA | capValB, 0);
    check(clrOut == 0, "R1 clrOut", clrOut, 0);
    rstN = 1'b1;

    // R2 plain counting
    zeroCount();
    cyc(10);
    check(count == 10, "R2 count", count, 10);

    // R3 prescaled sources
    for (int k = 1; k < 4; k++) begin
      srcSel = 3'(k); cyc(1);
      c0 = count; cyc(32);
      check(16'(count - c0) == 16'(32 >> k), "R3 divide", 16'(count - c0), 32 >> k);
    end

    // R5 latency and rising-only
    srcSel = 3'b100; edgeSel = 2'b00; cyc(2);
    c0 = count;
    extClkPin[0] = 1'b1; cyc(2);
    check(count == c0, "R5 before third edge", count, c0);
    cyc(1);
    check(count == c0 + 1, "R5 third edge", count, c0 + 1);
    extClkPin[0] = 1'b0; cyc(4);
    check(count == c0 + 1, "R5 fall ignored", count, c0 + 1);

    // R4 pin selection
    srcSel = 3'b101; c0 = count;
    pulseExt(1, 3);
    check(count == c0 + 3, "R4 pin1 counted", count, c0 + 3);
    c0 = count;
    pulseExt(0, 1); pulseExt(2, 1); pulseExt(3, 1);
    check(count == c0, "R4 other pins", count, c0);

    // R5 falling and both
    edgeSel = 2'b01; c0 = count; pulseExt(1, 2);
    check(count == c0 + 2, "R5 falling", count, c0 + 2);
    edgeSel = 2'b10; c0 = count; pulseExt(1, 2);
    check(count == c0 + 4, "R5 both", count, c0 + 4);
    edgeSel = 2'b11; c0 = count; pulseExt(1, 1);
    check(count == c0 + 2, "R5 both 11", count, c0 + 2);

    // R6 phase mode
    phaseMode = 1'b1; srcSel = 3'b100; c0 = count;
    pulseExt(0, 3);
    check(count == c0, "R6 ext blocked", count, c0);
    srcSel = 3'b000; c0 = count; cyc(10);
    check(count == c0 + 10, "R6 internal runs", count, c0 + 10);
    phaseMode = 1'b0; edgeSel = 2'b00;

    // R8 / R13 compare clear on A
    zeroCount();
    clrSel = 2'b01; cmpValA = 16'd5; capModeA = 1'b0;
    cyc(5);
    check(count == 5 && matchA, "R7 matchA", {count, 15'd0, matchA}, 5);
    check(clrOut == 1, "R8 clrOut A", clrOut, 1);
    cyc(1);
    check(count == 0, "R13 clear wins", count, 0);
    // compare clear on B
    zeroCount();
    clrSel = 2'b10; cmpValB = 16'd3; cyc(3);
    check(matchB && clrOut, "R8 matchB clrOut", {matchB, clrOut}, 3);
    cyc(1);
    check(count == 0, "R8 clear B", count, 0);

    // R7 capture mode suppresses match
    zeroCount();
    cmpValA = 16'd2; capModeA = 1'b1; cyc(2);
    check(matchA == 0, "R7 capture mode no match", matchA, 0);
    capModeA = 1'b0; #1;
    check(matchA == 1, "R7 compare mode match", matchA, 1);

    // R12 no clear, wrap
    zeroCount();
    clrSel = 2'b00; cmpValA = 16'd0; cmpValB = 16'd7;
    cyc(65535);
    check(count == 16'hFFFF, "R12 reaches top", count, 16'hFFFF);
    check(clrOut == 0, "R12 clrOut low", clrOut, 0);
    cyc(1);
    check(count == 0, "R2 wrap", count, 0);

    // R11 synchronized clear
    clrSel = 2'b11; syncEn = 1'b0; syncClrIn = 1'b1; c0 = count;
    cyc(4);
    check(count == c0 + 4, "R11 gated by syncEn", count, c0 + 4);
    check(clrOut == 0, "R11 clrOut low", clrOut, 0);
    syncEn = 1'b1; cyc(1);
    check(count == 0, "R11 sync clear", count, 0);
    syncEn = 1'b0; syncClrIn = 1'b0; clrSel = 2'b00;

    // R9 capture
    cyc(5);
    capModeA = 1'b1; capEdgeSel = 2'b00;
    c0 = count; capPinA = 1'b1; cyc(3);
    check(capValA == c0 + 2, "R9 rising capture", capValA, c0 + 2);
    capEdgeSel = 2'b01; c0 = count; capPinA = 1'b0; cyc(3);
    check(capValA == c0 + 2, "R9 falling capture", capValA, c0 + 2);
    c0 = capValA; capPinA = 1'b1; cyc(4);
    check(capValA == c0, "R9 rising ignored", capValA, c0);
    capModeB = 1'b1; capEdgeSel = 2'b10; c0 = count; capPinB = 1'b1; cyc(3);
    check(capValB == c0 + 2, "R9 B both edges", capValB, c0 + 2);

    // R10 clear on capture
    capEdgeSel = 2'b00; capPinA = 1'b0; cyc(4);
    clrSel = 2'b01; c0 = count; capPinA = 1'b1; cyc(2);
    check(clrOut == 1, "R10 clrOut", clrOut, 1);
    cyc(1);
    check(capValA == c0 + 2, "R10 captured pre-clear", capValA, c0 + 2);
    check(count == 0, "R10 counter cleared", count, 0);
    clrSel = 2'b00; capModeA = 1'b0; capModeB = 1'b0;

    // Random phase: R2 R8 R11 R13 against a bench model
    srcSel = 3'b000;
    for (int i = 0; i < 400; i++) begin
      clrSel    = 2'($urandom_range(0, 3));
      cmpValA   = 16'($urandom_range(0, 12));
      cmpValB   = 16'($urandom_range(0, 12));
      syncEn    = 1'($urandom_range(0, 1));
      syncClrIn = ($urandom_range(0, 7) == 0);
      #1;
      check(clrOut == modelClrOut(count), "R8 random clrOut", clrOut, modelClrOut(count));
      expNext = modelNext(count);
      cyc(1);
      check(count == expNext, "R13 random next count", count, expNext);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule